// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Sequencer

This block turns single read or write requests from a host port into complete cycles on a word-addressed asynchronous bus with a 16-bit data path and two byte strobes. Each bus cycle runs through eight timing states, S0 to S7. One state lasts one period of `clk`, so a pair of states equals one bus clock. A cycle with no wait states therefore takes eight `clk` periods. The block drives the address, the address strobe, the upper and lower data strobes, the read/write line and the write data together with its output enable. It then waits for the slave to acknowledge, captures read data, and reports the result to the host.

The request side uses valid/ready. `req_ready` is high only when no cycle is in progress. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The host must hold its request fields stable while `req_valid` is high and `req_ready` is low. The response side is a one-cycle pulse with no back-pressure: `rsp_valid` is high for exactly one cycle and carries `rsp_data` and `rsp_err`. The host must take the response in that cycle. A bus-error input aborts a stalled cycle early and returns an error status in place of data.

Top module: `bm_async_master`

## Requirements
- R1: While reset is asserted and whenever idle, `bus_as_n`, `bus_uds_n` and `bus_lds_n` are 1, `bus_rw` is 1, `bus_doe` is 0 and `req_ready` is 1.
- R2: A request transfers when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` stays low from that edge until the cycle in which `rsp_valid` is high.
- R3: `bus_addr` is zero in S0. It carries the request address from S1 to the end of S7, and it never changes while the address strobe stays low.
- R4: `bus_as_n` is low from S2 through S6, including any wait states, and high in S7. A data strobe is never low while the address strobe is high.
- R5: In a read, the selected data strobes are low from S2 through S6, and `bus_rw` stays 1 throughout.
- R6: In a write, `bus_rw` is 0 and `bus_doe` is 1 from S3 through S7. The selected data strobes are low only from S4 through S6.
- R7: `req_be[1]` selects the upper lane (`bus_uds_n`) and `req_be[0]` selects the lower lane (`bus_lds_n`). `req_be` = 11 is a word access, and `req_be` = 00 is also treated as a word access.
- R8: A write of the lower byte alone drives `req_wdata[7:0]` on both byte lanes of `bus_dout`. A write of the upper byte alone drives `req_wdata[15:8]` on both lanes. A word write drives `req_wdata` unchanged.
- R9: `bus_ack_n` is sampled only at the edge that ends S4, and then at the end of each whole bus clock of waiting. Each late sample adds two wait states, so a cycle with n late samples spans 8+2n clocks. An acknowledge given earlier than S4 does not shorten the cycle.
- R10: Read data on `bus_din` is captured at the edge that ends S6. `rsp_valid` pulses for one cycle right after S7, with `rsp_err` = 0. `rsp_data` holds the captured word for reads and is 0 for writes.
- R11: `bus_berr_n` low at the edge that ends S4 or any wait state sends the sequencer straight to S7 with all strobes high. The response that follows has `rsp_err` = 1 and `rsp_data` = 0.
- R12: If the bus error and the acknowledge are both low at the same sampling edge, the bus error wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per timing state |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 23 | Word address |
| req_be | input | 2 | Byte enables: bit 1 upper lane, bit 0 lower lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Cycle ended by a bus error |
| bus_addr | output | 23 | Bus address |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_rw | output | 1 | 1 read or idle, 0 write |
| bus_dout | output | 16 | Write data toward the bus |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | 16 | Read data from the bus |
| bus_ack_n | input | 1 | Slave acknowledge, active low |
| bus_berr_n | input | 1 | Bus error, active low |

## Verification
After a request transfers at clock edge E, S0 occupies the cycle that follows E. With n wait pairs, S7 falls on cycle 7+2n and the response pulse on cycle 8+2n. After a bus error sampled at the end of cycle k, S7 falls on cycle k+1 and the response on k+2. The bench counts cycles from the transfer edge. It samples every bus pin at each falling edge against the state expected for that cycle number. It drives the acknowledge and the error in the cycle whose closing edge must sample them. It then checks the response in the one cycle where it is due, and checks that the pulse has gone in the cycle after.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_S6, ST_S7, ST_W1, ST_W2
  } bm_state_e;
endpackage

// File: rtl/bm_seq.sv
module bm_seq
  import bm_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              ack_n,
  input  logic              berr_n,
  output bm_state_e         state_o,
  output logic              cyc_write,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [1:0]        cyc_be,
  output logic [DATA_W-1:0] cyc_wdata
);
  bm_state_e state_q, state_d;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;
  logic              sample_pt;
  logic              accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign state_o   = state_q;
  // the three edges where the error input is looked at
  assign sample_pt = (state_q == ST_S4) || (state_q == ST_W1) || (state_q == ST_W2);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_S0;
      ST_S0:   state_d = ST_S1;
      ST_S1:   state_d = ST_S2;
      ST_S2:   state_d = ST_S3;
      ST_S3:   state_d = ST_S4;
      ST_S4: begin
        if (!berr_n)     state_d = ST_S7;
        else if (!ack_n) state_d = ST_S5;
        else             state_d = ST_W1;
      end
      ST_W1:   state_d = berr_n ? ST_W2 : ST_S7;
      ST_W2: begin
        if (!berr_n)     state_d = ST_S7;
        else if (!ack_n) state_d = ST_S5;
        else             state_d = ST_W1;
      end
      ST_S5:   state_d = ST_S6;
      ST_S6:   state_d = ST_S7;
      ST_S7:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      err_q     <= 1'b0;
      rdata_q   <= '0;
      cyc_write <= 1'b0;
      cyc_addr  <= '0;
      cyc_be    <= 2'b11;
      cyc_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cyc_write <= req_write;
        cyc_addr  <= req_addr;
        cyc_be    <= (req_be == 2'b00) ? 2'b11 : req_be;
        cyc_wdata <= req_wdata;
        err_q     <= 1'b0;
      end else if (sample_pt && !berr_n) begin
        err_q <= 1'b1;
      end
      if (state_q == ST_S6) rdata_q <= bus_din;
      rsp_valid <= (state_q == ST_S7);
      if (state_q == ST_S7) begin
        rsp_err  <= err_q;
        rsp_data <= (err_q || cyc_write) ? '0 : rdata_q;
      end
    end
  end

  a_r9_late_ack_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_S4 && ack_n && berr_n) |=> state_q == ST_W1);
  a_r9_wait_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_W1) |=> (state_q == ST_W2 || state_q == ST_S7));
  a_r12_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && !berr_n) |=> state_q == ST_S7);
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r11_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_data == '0);
endmodule

// File: rtl/bm_lanes.sv
module bm_lanes
  import bm_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  bm_state_e         state_i,
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [1:0]        cyc_be,
  input  logic [DATA_W-1:0] cyc_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic              bus_rw,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe
);
  localparam int LANE_W = DATA_W / 2;

  logic in_wait, addr_on, as_on, ds_on, wr_on;

  always_comb begin
    in_wait = (state_i == ST_W1) || (state_i == ST_W2);
    addr_on = (state_i != ST_IDLE) && (state_i != ST_S0);
    as_on   = in_wait || (state_i inside {ST_S2, ST_S3, ST_S4, ST_S5, ST_S6});
    // writes delay the data strobes by one bus clock
    ds_on   = in_wait || (cyc_write ? (state_i inside {ST_S4, ST_S5, ST_S6})
                                    : (state_i inside {ST_S2, ST_S3, ST_S4, ST_S5, ST_S6}));
    wr_on   = cyc_write && (in_wait || (state_i inside {ST_S3, ST_S4, ST_S5, ST_S6, ST_S7}));

    bus_addr  = addr_on ? cyc_addr : '0;
    bus_as_n  = !as_on;
    bus_uds_n = !(ds_on && cyc_be[1]);
    bus_lds_n = !(ds_on && cyc_be[0]);
    bus_rw    = !wr_on;
    bus_doe   = wr_on;
    unique case (cyc_be)
      2'b01:   bus_dout = {2{cyc_wdata[LANE_W-1:0]}};
      2'b10:   bus_dout = {2{cyc_wdata[DATA_W-1:LANE_W]}};
      default: bus_dout = cyc_wdata;
    endcase
  end
endmodule

// File: rtl/bm_async_master.sv
module bm_async_master
  import bm_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic              bus_rw,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_ack_n,
  input  logic              bus_berr_n
);
  bm_state_e         state;
  logic              cyc_write;
  logic [ADDR_W-1:0] cyc_addr;
  logic [1:0]        cyc_be;
  logic [DATA_W-1:0] cyc_wdata;

  bm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .bus_din(bus_din), .ack_n(bus_ack_n), .berr_n(bus_berr_n),
    .state_o(state), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .cyc_be(cyc_be), .cyc_wdata(cyc_wdata)
  );

  bm_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
    .state_i(state), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .cyc_be(cyc_be), .cyc_wdata(cyc_wdata),
    .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
    .bus_lds_n(bus_lds_n), .bus_rw(bus_rw), .bus_dout(bus_dout), .bus_doe(bus_doe)
  );

  a_r4_ds_within_as: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_uds_n || !bus_lds_n) |-> !bus_as_n);
  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_addr));
  a_r6_data_before_ds: assert property (@(posedge clk) disable iff (!rst_n)
    ((!bus_uds_n || !bus_lds_n) && !bus_rw) |-> (bus_doe && $past(bus_doe)));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_as_n && bus_uds_n && bus_lds_n && bus_rw && !bus_doe));
endmodule

// File: tb/tb_bm_async_master.sv
module tb_bm_async_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0, bus_din = '0;
  logic        bus_ack_n = 1'b1, bus_berr_n = 1'b1;
  logic        req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_data, bus_dout;
  logic [22:0] bus_addr;
  logic        bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_doe;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bm_async_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
    .bus_rw(bus_rw), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_ack_n(bus_ack_n), .bus_berr_n(bus_berr_n)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // phase of cycle k after transfer; 8 stands for a wait state
  function automatic int phase(int k, int nw, int errk);
    if (errk >= 0 && k == errk + 1) return 7;
    if (k < 5) return k;
    if (errk >= 0) return 8;
    if (k < 5 + 2 * nw) return 8;
    return k - 2 * nw;
  endfunction

  task automatic run_cyc(input bit wr, input logic [22:0] ad, input logic [1:0] be,
                         input logic [15:0] wd, input logic [15:0] sd, input int nw,
                         input int errk, input bit early_ack, input bit ack_at_err,
                         input string tag);
    int last;
    logic [1:0] bee;
    logic [15:0] dexp;
    bee  = (be == 2'b00) ? 2'b11 : be;
    dexp = (bee == 2'b01) ? {2{wd[7:0]}} : (bee == 2'b10) ? {2{wd[15:8]}} : wd;
    last = (errk >= 0) ? errk + 1 : 7 + 2 * nw;
    @(negedge clk);
    req_write = wr; req_addr = ad; req_be = be; req_wdata = wd; req_valid = 1'b1;
    chk(req_ready === 1'b1, "R2 ready before transfer", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= last; k++) begin
      int p;
      bit as_l, ds_w, wr_l;
      logic [27:0] e, a;
      p    = phase(k, nw, errk);
      as_l = (p >= 2 && p <= 6) || p == 8;
      ds_w = wr ? ((p >= 4 && p <= 6) || p == 8) : ((p >= 2 && p <= 6) || p == 8);
      wr_l = wr && ((p >= 3 && p <= 7) || p == 8);
      e = {!as_l, !(ds_w && bee[1]), !(ds_w && bee[0]), !wr_l, wr_l, (p == 0) ? 23'd0 : ad};
      a = {bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_doe, bus_addr};
      chk(a === e, {tag, " R3 R4 R5 R6 R7 R9 pins"}, a, e);
      if (wr_l) chk(bus_dout === dexp, {tag, " R8 write lanes"}, bus_dout, dexp);
      chk(req_ready === 1'b0 && rsp_valid === 1'b0, {tag, " R2 busy"}, {req_ready, rsp_valid}, 0);
      bus_din = sd;
      if (k < last) begin
        if (errk >= 0) begin
          bus_berr_n = !(k == errk);
          bus_ack_n  = !(ack_at_err && k == errk);
        end else begin
          bus_berr_n = 1'b1;
          bus_ack_n  = !(early_ack || k >= 4 + 2 * nw);
        end
      end else begin
        bus_ack_n = 1'b1; bus_berr_n = 1'b1;
      end
      @(negedge clk);
    end
    if (errk >= 0)
      chk(rsp_valid === 1 && rsp_err === 1 && rsp_data === 16'h0 && req_ready === 1,
          {tag, " R11 R12 error response"}, {rsp_valid, rsp_err, rsp_data, req_ready}, {1'b1, 1'b1, 16'h0, 1'b1});
    else
      chk(rsp_valid === 1 && rsp_err === 0 && rsp_data === (wr ? 16'h0 : sd) && req_ready === 1,
          {tag, " R10 response"}, {rsp_valid, rsp_err, rsp_data, req_ready},
          {1'b1, 1'b0, (wr ? 16'h0 : sd), 1'b1});
    @(negedge clk);
    chk(rsp_valid === 1'b0, {tag, " R10 single pulse"}, rsp_valid, 0);
  endtask

  // {write, be, waits, addr, wdata, slave data}
  localparam logic [60:0] VECS [6] = '{
    {1'b0, 2'b11, 3'd0, 23'h012345, 16'h0000, 16'hBEEF},
    {1'b1, 2'b11, 3'd0, 23'h7ABCDE, 16'hA55A, 16'h0000},
    {1'b1, 2'b01, 3'd1, 23'h000010, 16'h1234, 16'h0000},
    {1'b0, 2'b10, 3'd2, 23'h400001, 16'h0000, 16'hC3D2},
    {1'b1, 2'b10, 3'd0, 23'h155555, 16'h9A7B, 16'h0000},
    {1'b0, 2'b00, 3'd3, 23'h2AAAAA, 16'h0000, 16'h0F0F}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk({req_ready, bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_doe} === 6'b111110,
        "R1 in reset", {req_ready, bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_doe}, 6'b111110);
    rst_n = 1'b1;
    @(negedge clk);
    chk({req_ready, bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_doe, rsp_valid} === 7'b1111100,
        "R1 idle after reset", {req_ready, bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_doe, rsp_valid}, 7'b1111100);

    for (int i = 0; i < 6; i++) begin
      logic [60:0] v;
      v = VECS[i];
      run_cyc(v[60], v[54:32], v[59:58], v[31:16], v[15:0], int'(v[57:55]), -1, 1'b0, 1'b0, "vec");
    end

    // R9: acknowledge low from S0 still gives a full eight-state cycle
    run_cyc(1'b0, 23'h003C00, 2'b01, 16'h0, 16'h5AA5, 0, -1, 1'b1, 1'b0, "early ack");
    // R11: bus error in a wait state of a stalled read
    run_cyc(1'b0, 23'h0F0F0F, 2'b11, 16'h0, 16'h1111, 9, 7, 1'b0, 1'b0, "berr in wait");
    // R12: error and acknowledge together at the end of S4 of a write
    run_cyc(1'b1, 23'h055AA0, 2'b11, 16'h6C6C, 16'h0, 0, 4, 1'b0, 1'b1, "berr with ack");
    // R8: single lower-byte write with no waits
    run_cyc(1'b1, 23'h000002, 2'b01, 16'hFE01, 16'h0, 0, -1, 1'b0, 1'b0, "low byte");

    @(negedge clk);
    chk({req_ready, bus_as_n, bus_rw, bus_doe} === 4'b1110, "R1 idle at end",
        {req_ready, bus_as_n, bus_rw, bus_doe}, 4'b1110);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule